// File: doc/BRIEF.md
# Status Register Transfer Unit

This unit carries out the two status-transfer operations of a 32-bit processor core. One copies a value into a status word. The other copies a status word out to a general register. The unit sits beside the execute stage. Each cycle that `op_valid` is high, it decodes the instruction word and takes in the current status word and the source register value. One cycle later it presents a registered result. For a write, that result is a new current status word for the core to commit, or an update to one of its own saved-status registers. For a read, it is a destination register index and the value to place there.

The unit holds five saved-status words, one for each privileged mode. The mode field of the current status chooses which one an operation uses. A write changes only the bytes that the instruction enables, and the mode and the target narrow that set further. When a write to the current status changes the mode field, the unit raises a one-cycle pulse so that the core can switch its banked registers. An operation on a saved status while the core is in a mode that has no saved status is dropped and flagged.

Top module: `srt_unit`

## Requirements
- R1: Instruction bit 20 = 1 selects a write and 0 selects a read. Bit 22 = 0 targets the current status and 1 targets the saved status of the current mode. Every result appears on registered outputs in the cycle after `op_valid`. In any cycle after `op_valid` was low, all strobes (`cur_we`, `sav_we`, `rd_we`, `mode_chg`, `op_reject`) are low, and at most one of `cur_we`, `sav_we`, `rd_we`, `op_reject` is high.
- R2: The mode field, `cur_status[4:0]`, selects the saved word: 0x11, 0x12, 0x13, 0x17 and 0x1B each have a saved word of their own. If bit 22 = 1 and the mode is any other value, the operation does nothing: no saved word changes, `op_reject` pulses, and no other strobe is raised.
- R3: Instruction bits 16, 17, 18 and 19 enable writes to status bits 7:0, 15:8, 23:16 and 31:24 respectively.
- R4: A write to the current status never changes bit 5. The new word keeps bit 5 of `cur_status`. A write to a saved word may change bit 5.
- R5: When the mode is 0x10, a write to the current status leaves bits 7:0 equal to those of `cur_status`.
- R6: When instruction bit 25 = 1, the operand is instruction bits 7:0, zero-extended and rotated right by twice the value of bits 11:8.
- R7: When bit 25 = 0, the operand is `src_val`. `src_idx` shows instruction bits 3:0 without delay, so that the register file can supply that register.
- R8: The written word is (old AND NOT mask) OR (operand AND mask). It appears on `psr_out` with `cur_we` (for a current-status target) or with `sav_we` (for a saved target, which is also stored).
- R9: A read raises `rd_we`, sets `rd_idx` to instruction bits 15:12, and sets `rd_data` to `cur_status` (bit 22 = 0) or to the selected saved word (bit 22 = 1). A read that follows a saved write returns the stored value.
- R10: `mode_chg` pulses together with `cur_we` exactly when the new current word differs from `cur_status` in bits 4:0.
- R11: After reset, every saved word reads as zero and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A status-transfer instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| src_val | input | 32 | Value of the register named by `src_idx` |
| cur_status | input | 32 | Current status word of the core |
| src_idx | output | 4 | Source register index (instruction bits 3:0) |
| cur_we | output | 1 | Commit `psr_out` as the new current status |
| sav_we | output | 1 | A saved word was updated to `psr_out` |
| psr_out | output | 32 | Newly written status word |
| rd_we | output | 1 | Write `rd_data` to register `rd_idx` |
| rd_idx | output | 4 | Destination register index |
| rd_data | output | 32 | Status word that was read |
| mode_chg | output | 1 | A current-status write changed the mode field |
| op_reject | output | 1 | A saved-status operation was dropped because the mode has no saved word |

## Verification
The hardest thing to observe from the ports is a saved word. It is visible only through a later read, and only while the core reports the same mode. After every saved-status write, the bench therefore issues a saved-status read in the same mode and compares the result with its own model of the bank. Saved-status writes are also made while the core reports each invalid mode, and the reads that follow show that no saved word changed. The sweep covers every combination of mode (valid, user and invalid), byte-enable pattern, target and operand form. Together these cover the narrowing of the mask by mode and target, and the mode-change pulse.

// File: rtl/srt_pkg.sv
// Package: shared constants, types and decode helpers for the status
// register transfer unit. Assumes a 32-bit instruction word whose bit
// positions are fixed by the instruction encoding.
package srt_pkg;

    localparam int INSTR_W   = 32;
    localparam int MODE_W    = 5;
    localparam int NUM_SAVED = 5;
    localparam int SLOT_W    = $clog2(NUM_SAVED);
    localparam int IMM_W     = 8;
    localparam int ROT_W     = 4;
    localparam int IDX_W     = 4;
    localparam int FLD_W     = 4;

    localparam int BIT_WRITE = 20;
    localparam int BIT_SAVED = 22;
    localparam int BIT_IMM   = 25;
    localparam int FLD_LO    = 16;
    localparam int RD_LO     = 12;
    localparam int ROT_LO    = 8;
    localparam int IMM_LO    = 0;
    localparam int RS_LO     = 0;
    localparam int STATE_BIT = 5;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'h10,
        MODE_FIQ = 5'h11,
        MODE_IRQ = 5'h12,
        MODE_SVC = 5'h13,
        MODE_ABT = 5'h17,
        MODE_UND = 5'h1B
    } mode_e;

    typedef struct packed {
        logic             is_write;
        logic             to_saved;
        logic             is_imm;
        logic [FLD_W-1:0] fields;
        logic [IDX_W-1:0] rd_idx;
        logic [ROT_W-1:0] rot;
        logic [IMM_W-1:0] imm;
    } op_t;

    typedef struct packed {
        logic              ok;
        logic [SLOT_W-1:0] idx;
    } slot_t;

    // Pull the fields this unit acts on out of an instruction word.
    function automatic op_t decode_op(input logic [INSTR_W-1:0] w);
        op_t o;
        o.is_write = w[BIT_WRITE];
        o.to_saved = w[BIT_SAVED];
        o.is_imm   = w[BIT_IMM];
        o.fields   = w[FLD_LO +: FLD_W];
        o.rd_idx   = w[RD_LO +: IDX_W];
        o.rot      = w[ROT_LO +: ROT_W];
        o.imm      = w[IMM_LO +: IMM_W];
        return o;
    endfunction

    // Map a mode code to the saved-status slot it owns, if any.
    function automatic slot_t mode_slot(input logic [MODE_W-1:0] m);
        slot_t s;
        s.ok  = 1'b1;
        s.idx = '0;
        case (m)
            MODE_FIQ: s.idx = SLOT_W'(0);
            MODE_IRQ: s.idx = SLOT_W'(1);
            MODE_SVC: s.idx = SLOT_W'(2);
            MODE_ABT: s.idx = SLOT_W'(3);
            MODE_UND: s.idx = SLOT_W'(4);
            default:  s.ok  = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/srt_operand.sv
// Operand former: picks either the rotated immediate or the register
// value. Purely combinational. Assumes DATA_W is a power of two, at
// least IMM_W wide.
module srt_operand #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic              is_imm,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] operand
);
    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0]   imm_ext;
    logic [SH_W-1:0]     amount;
    logic [2*DATA_W-1:0] doubled;

    // Rotate the zero-extended immediate right by twice the rotate field.
    always_comb begin
        imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm};
        amount  = SH_W'({rot, 1'b0});
        doubled = {imm_ext, imm_ext} >> amount;
        operand = is_imm ? doubled[DATA_W-1:0] : reg_val;
    end

    // R6: rotating by zero leaves the immediate unchanged.
    always_comb begin
        if (is_imm && rot == '0) begin
            a_zero_rot_r6: assert (operand == imm_ext);
        end
    end
endmodule

// File: rtl/srt_mask.sv
// Write-mask builder: one enable per status byte, then the target and
// mode restrictions. Combinational. Assumes DATA_W is a multiple of 8
// and wider than STATE_BIT.
module srt_mask #(
    parameter int DATA_W    = 32,
    parameter int STATE_BIT = 5
) (
    input  logic [DATA_W/8-1:0] fields,
    input  logic                to_saved,
    input  logic                user_mode,
    output logic [DATA_W-1:0]   mask
);
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] raw;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign raw[b*8 +: 8] = {8{fields[b]}};
    end

    // Narrow the byte mask by target and privilege.
    always_comb begin
        mask = raw;
        if (user_mode) begin
            mask[7:0] = 8'h00;
        end
        if (!to_saved) begin
            mask[STATE_BIT] = 1'b0;
        end
    end

    // R5: in user mode the low byte is never enabled.
    always_comb begin
        if (user_mode) begin
            a_user_low_r5: assert (mask[7:0] == 8'h00);
        end
    end
endmodule

// File: rtl/srt_bank.sv
// Saved-status bank: one register per privileged mode, one write port
// and one combinational read port. Synchronous active-low reset clears
// all words. Assumes the slot indices presented are below NUM.
module srt_bank #(
    parameter int DATA_W = 32,
    parameter int NUM    = 5,
    localparam int SLOT_W = $clog2(NUM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM-1:0][DATA_W-1:0] q;

    // Store the written word into the selected slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM; i++) begin
                if (wr_slot == SLOT_W'(i)) begin
                    q[i] <= wr_data;
                end
            end
        end
    end

    // Read mux over the slots.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM; i++) begin
            if (rd_slot == SLOT_W'(i)) begin
                rd_data = q[i];
            end
        end
    end

    // R2: without a write, no saved word changes.
    p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/srt_unit.sv
// Status register transfer unit top. Decodes status move operations,
// forms the operand and mask, merges the new word and registers all
// results one cycle after op_valid. Assumes cur_status is the core's
// committed status word for the cycle in which op_valid is high.
module srt_unit
    import srt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  src_val,
    input  logic [DATA_W-1:0]  cur_status,
    output logic [IDX_W-1:0]   src_idx,
    output logic               cur_we,
    output logic               sav_we,
    output logic [DATA_W-1:0]  psr_out,
    output logic               rd_we,
    output logic [IDX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic               mode_chg,
    output logic               op_reject
);
    op_t               op;
    slot_t             slot;
    logic [MODE_W-1:0] mode;
    logic              user_mode;
    logic              blocked;
    logic              do_cur_wr;
    logic              do_sav_wr;
    logic              do_rd;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] saved_old;
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] merged;

    // Decode the instruction and classify the operation.
    always_comb begin
        op        = decode_op(instr);
        mode      = cur_status[MODE_W-1:0];
        slot      = mode_slot(mode);
        user_mode = (mode == MODE_USR);
        blocked   = op.to_saved && !slot.ok;
        do_cur_wr = op_valid && op.is_write && !op.to_saved;
        do_sav_wr = op_valid && op.is_write && op.to_saved && slot.ok;
        do_rd     = op_valid && !op.is_write && !blocked;
    end

    assign src_idx = instr[RS_LO +: IDX_W];

    srt_operand #(
        .DATA_W(DATA_W),
        .IMM_W (IMM_W),
        .ROT_W (ROT_W)
    ) u_operand (
        .is_imm (op.is_imm),
        .imm    (op.imm),
        .rot    (op.rot),
        .reg_val(src_val),
        .operand(operand)
    );

    srt_mask #(
        .DATA_W   (DATA_W),
        .STATE_BIT(STATE_BIT)
    ) u_mask (
        .fields   (op.fields),
        .to_saved (op.to_saved),
        .user_mode(user_mode),
        .mask     (mask)
    );

    srt_bank #(
        .DATA_W(DATA_W),
        .NUM   (NUM_SAVED)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (do_sav_wr),
        .wr_slot(slot.idx),
        .wr_data(merged),
        .rd_slot(slot.idx),
        .rd_data(saved_old)
    );

    // Merge the operand into the selected old word under the mask.
    always_comb begin
        old_word = op.to_saved ? saved_old : cur_status;
        merged   = (old_word & ~mask) | (operand & mask);
    end

    // Register the strobes and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_we    <= 1'b0;
            sav_we    <= 1'b0;
            rd_we     <= 1'b0;
            mode_chg  <= 1'b0;
            op_reject <= 1'b0;
            psr_out   <= '0;
            rd_idx    <= '0;
            rd_data   <= '0;
        end else begin
            cur_we    <= do_cur_wr;
            sav_we    <= do_sav_wr;
            rd_we     <= do_rd;
            op_reject <= op_valid && blocked;
            mode_chg  <= do_cur_wr && (merged[MODE_W-1:0] != cur_status[MODE_W-1:0]);
            if (do_cur_wr || do_sav_wr) begin
                psr_out <= merged;
            end
            if (do_rd) begin
                rd_idx  <= op.rd_idx;
                rd_data <= old_word;
            end
        end
    end

    // R1: no strobe follows an idle cycle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !(cur_we || sav_we || rd_we || mode_chg || op_reject));

    // R1: the operation kinds are mutually exclusive.
    p_one_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cur_we, sav_we, rd_we, op_reject}));

    // R2: an operation on a missing saved word is rejected.
    p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op.to_saved && !slot.ok) |=> (op_reject && !sav_we && !rd_we && !cur_we));

    // R4: a current-status write keeps the state bit.
    p_state_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op.is_write && !op.to_saved) |=> (cur_we && psr_out[STATE_BIT] == $past(cur_status[STATE_BIT])));

    // R5: a user-mode current write keeps the low byte.
    p_user_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op.is_write && !op.to_saved && mode == MODE_USR) |=> (psr_out[7:0] == $past(cur_status[7:0])));

    // R10: a mode change only comes with a current-status write.
    p_mode_chg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> cur_we);
endmodule

// File: tb/tb_srt_unit.sv
module tb_srt_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [31:0] instr;
    logic [31:0] src_val;
    logic [31:0] cur_status;
    logic [3:0]  src_idx;
    logic        cur_we, sav_we, rd_we, mode_chg, op_reject;
    logic [31:0] psr_out, rd_data;
    logic [3:0]  rd_idx;

    int nchk  = 0;
    int nfail = 0;
    logic [31:0] model [5];
    logic [4:0]  modes [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h00};

    always #5 clk = ~clk;

    srt_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr),
        .src_val(src_val), .cur_status(cur_status), .src_idx(src_idx),
        .cur_we(cur_we), .sav_we(sav_we), .psr_out(psr_out), .rd_we(rd_we),
        .rd_idx(rd_idx), .rd_data(rd_data), .mode_chg(mode_chg), .op_reject(op_reject)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [4:0] m);
        case (m)
            5'h11: return 0;
            5'h12: return 1;
            5'h13: return 2;
            5'h17: return 3;
            5'h1B: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] ror32(input logic [31:0] v, input int n);
        logic [31:0] r = v;
        for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
        return r;
    endfunction

    function automatic logic [31:0] mk(input bit w, input bit sv, input bit im,
                                       input logic [3:0] f, input logic [3:0] rd,
                                       input logic [3:0] rot, input logic [7:0] i8);
        logic [31:0] x = 32'hE0000000;
        x[20] = w; x[22] = sv; x[25] = im;
        x[19:16] = f; x[15:12] = rd; x[11:8] = rot; x[7:0] = i8;
        return x;
    endfunction

    function automatic logic [31:0] pat(input int k);
        return (32'(k) * 32'h9E3779B9) ^ 32'h5A5A0000;
    endfunction

    // Issue one operation and check every registered result in the next cycle.
    task automatic run_op(input logic [31:0] ins, input logic [31:0] src,
                          input logic [31:0] cur, input string tag);
        bit w = ins[20], sv = ins[22], im = ins[25];
        int s = slot_of(cur[4:0]);
        bit blk = sv && (s < 0);
        logic [31:0] opnd, m, old, nw;
        bit e_cw, e_sw, e_rd, e_mc;
        opnd = im ? ror32({24'h0, ins[7:0]}, 2 * int'(ins[11:8])) : src;
        m = 32'h0;
        for (int b = 0; b < 4; b++) if (ins[16+b]) m |= (32'hFF << (8*b));
        if (!sv) m &= ~32'h20;
        if (cur[4:0] == 5'h10) m &= ~32'hFF;
        old = sv ? ((s >= 0) ? model[s] : 32'h0) : cur;
        nw = (old & ~m) | (opnd & m);
        e_cw = w && !sv;
        e_sw = w && sv && !blk;
        e_rd = !w && !blk;
        e_mc = e_cw && (nw[4:0] != cur[4:0]);
        @(negedge clk);
        instr = ins; src_val = src; cur_status = cur; op_valid = 1'b1;
        @(posedge clk); #1;
        chk("R1 cur_we", {31'b0, cur_we}, {31'b0, e_cw});
        chk("R1 sav_we", {31'b0, sav_we}, {31'b0, e_sw});
        chk("R1 rd_we", {31'b0, rd_we}, {31'b0, e_rd});
        chk("R2 op_reject", {31'b0, op_reject}, {31'b0, blk});
        chk("R10 mode_chg", {31'b0, mode_chg}, {31'b0, e_mc});
        if (e_cw || e_sw) chk(tag, psr_out, nw);
        if (e_rd) begin
            chk("R9 rd_idx", {28'b0, rd_idx}, {28'b0, ins[15:12]});
            chk("R9 rd_data", rd_data, old);
        end
        if (e_sw) model[s] = nw;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) model[i] = 32'h0;
        rst_n = 1'b0; op_valid = 1'b0; instr = '0; src_val = '0; cur_status = 32'h13;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R11: strobes are low after reset.
        chk("R11 strobes", {27'b0, cur_we, sav_we, rd_we, mode_chg, op_reject}, 32'h0);
        // R11: every saved word reads zero.
        for (int i = 1; i < 6; i++)
            run_op(mk(0, 1, 0, 4'h0, 4'(i), 4'h0, 8'h00), 32'h0, {27'h0, modes[i]}, "R11");

        // R7: src_idx follows instruction bits 3:0 with no delay.
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); instr = mk(1, 0, 0, 4'h8, 4'h0, 4'h0, {4'hA, 4'(i)}); #1;
            chk("R7 src_idx", {28'b0, src_idx}, 32'(i));
        end

        // R1: an idle cycle raises no strobe even with a write word present.
        @(negedge clk); instr = mk(1, 0, 1, 4'hF, 4'h1, 4'h0, 8'hFF); cur_status = 32'h13;
        @(posedge clk); #1;
        chk("R1 idle", {27'b0, cur_we, sav_we, rd_we, mode_chg, op_reject}, 32'h0);

        // R6: every rotate amount applied to the immediate.
        for (int r = 0; r < 16; r++)
            run_op(mk(1, 0, 1, 4'hF, 4'h0, 4'(r), 8'hC3), 32'h0, 32'h000000D3, "R6");

        // R7: register form in a privileged mode.
        for (int k = 0; k < 8; k++)
            run_op(mk(1, 0, 0, 4'hF, 4'h0, 4'h0, 8'(k)), pat(k + 100), 32'h0000001F, "R7");

        // R8: an empty byte mask leaves the word unchanged.
        run_op(mk(1, 0, 1, 4'h0, 4'h0, 4'h0, 8'hFF), 32'h0, 32'hA5A5A513, "R8");
        // R10: rewriting the same mode raises no pulse.
        run_op(mk(1, 0, 0, 4'h1, 4'h0, 4'h0, 8'h00), 32'hFFFFFF13, 32'h00000013, "R10");
        // R4: state bit survives a full-mask current write.
        run_op(mk(1, 0, 0, 4'hF, 4'h0, 4'h0, 8'h00), 32'h00000013, 32'h00000033, "R4");

        // Sweep every mode, byte mask, target and operand form.
        for (int mi = 0; mi < 8; mi++)
            for (int f = 0; f < 16; f++)
                for (int t = 0; t < 2; t++)
                    for (int im = 0; im < 2; im++) begin
                        int k = ((mi * 16 + f) * 2 + t) * 2 + im;
                        logic [31:0] cur = pat(k);
                        logic [31:0] ins = mk(1, t[0], im[0], 4'(f), 4'h0, 4'(k), 8'(k * 7));
                        string tg;
                        cur[4:0] = modes[mi];
                        cur[5] = k[1];
                        if (modes[mi] == 5'h10 && t == 0) tg = "R5";
                        else if (t == 0) tg = "R4";
                        else tg = "R3";
                        run_op(ins, pat(k + 999), cur, tg);
                        // R9: read back the saved word for this mode; R2 for invalid modes.
                        if (t == 1) run_op(mk(0, 1, 0, 4'h0, 4'(f), 4'h0, 8'h00), 32'h0, cur, "R9");
                        else run_op(mk(0, 0, 0, 4'h0, 4'(f), 4'h0, 8'h00), 32'h0, cur, "R9");
                    end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule